// File: doc/BRIEF.md
# MMIO Segment Decoder with Per-PE Freeze

This block sorts 32-bit PCI-side memory accesses for a host bridge that carves one fixed-size MMIO window into equal segments. The window is 1 GiB and 128 segments by default, so each segment is 8 MiB. The window must be aligned to its own size, so the base register holds only the address bits above the window size. A segment index is taken from the address bits just under the window tag. The index selects a remap entry, and that entry names the partitionable endpoint (PE) that owns the segment. Several adjacent segments may name the same PE, so one large device range can span them.

Each segment also holds a claimed-byte limit. An access whose offset within its segment is at or past that limit did not land on any device. Such an access is refused, and the owning PE enters a frozen state. While a PE is frozen, every access to it is refused, whatever its offset. Other PEs keep working. Software releases a PE by writing the PE number to the clear register. The decision for each request comes out one cycle after the request as a registered verdict: decoded, forwarded, or refused, together with the PE number.

Top module: `mmio_seg_decoder`

## Requirements
- R1: After reset the response valid, hit, forward and error outputs are low. The window base is 0xC000_0000. Segment i maps to PE i. Every segment claims its whole 8 MiB. No PE is frozen.
- R2: A request whose bits [31:30] differ from the base tag gets a response with hit=0, fwd=0, err=0 and pe=0.
- R3: For a request inside the window, the segment index is bits [29:23] and the reported PE is the remap entry of that segment.
- R4: Remap writes take wdata[6:0] as the PE for segment cfg_idx_i. Two segments mapped to the same PE both report that PE.
- R5: An in-window request to an unfrozen PE whose offset (bits [22:0]) is below its segment's limit is forwarded: fwd=1, err=0.
- R6: An in-window request to an unfrozen PE whose offset is at or above the segment limit gets err=1 and fwd=0, and freezes that PE. Other PEs are unaffected. Limit writes take wdata[23:0].
- R7: Any in-window request to a frozen PE gets err=1 and fwd=0, whatever its offset or segment.
- R8: A clear write (sel=3, wdata[6:0]=PE) unfreezes that PE from the next cycle on. It does not affect other PEs. If a freeze and a clear hit the same PE in the same cycle, the PE stays frozen.
- R9: rsp_valid_o is high exactly in the cycle after a cycle with req_valid_i high. When it is low, fwd and err are low.
- R10: A base write (sel=0) takes wdata[31:30] as the new window tag and ignores wdata[29:0].
- R11: A configuration write issued in the same cycle as a request does not affect that request. It affects requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Target: 0 base, 1 remap, 2 limit, 3 freeze clear |
| cfg_idx_i | input | 7 | Segment index for remap and limit writes |
| cfg_wdata_i | input | 32 | Write data |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | 32 | PCI-side access address |
| rsp_valid_o | output | 1 | Verdict valid |
| rsp_hit_o | output | 1 | Address fell inside the window |
| rsp_fwd_o | output | 1 | Access forwarded to its PE |
| rsp_err_o | output | 1 | Access refused with error |
| rsp_pe_o | output | 7 | Owning PE number |

## Verification
Most faults in the remap table or the limits show up on the first access to the affected segment: the verdict that follows one cycle later has the wrong PE or the wrong forward/error choice. A freeze bit that is lost, stuck or misindexed stays hidden until a later access reaches that PE. For that reason the stimulus revisits frozen PEs through segments other than the one that froze them, and it also probes a PE that was never frozen. The same-cycle ordering rules, write against request and clear against freeze, only show one access later, so each such case is followed at once by a probe access.

// File: rtl/mmio_seg_pkg.sv
package mmio_seg_pkg;
  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_MAP   = 2'd1,
    CFG_LIMIT = 2'd2,
    CFG_CLEAR = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic hit;
    logic fwd;
    logic err;
  } verdict_t;
endpackage

// File: rtl/mmio_win_regs.sv
module mmio_win_regs
  import mmio_seg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_LOG2 = 30,
  parameter int unsigned NUM_SEG  = 128,
  parameter int unsigned SEG_W    = 7,
  parameter int unsigned PE_W     = 7,
  parameter int unsigned LIM_W    = 24,
  parameter int unsigned SEG_SHIFT = 23,
  parameter logic [ADDR_W-1:0] BASE_RST = 32'hC000_0000,
  localparam int unsigned TAG_W = ADDR_W - WIN_LOG2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               cfg_we_i,
  input  logic [1:0]                         cfg_sel_i,
  input  logic [SEG_W-1:0]                   cfg_idx_i,
  input  logic [ADDR_W-1:0]                  cfg_wdata_i,
  output logic [TAG_W-1:0]                   base_tag_o,
  output logic [NUM_SEG-1:0][PE_W-1:0]       map_o,
  output logic [NUM_SEG-1:0][LIM_W-1:0]      limit_o
);
  localparam logic [LIM_W-1:0] LIM_FULL = LIM_W'(1) << SEG_SHIFT;

  logic wr_base, wr_map, wr_lim;
  assign wr_base = cfg_we_i && (cfg_sel_i == CFG_BASE);
  assign wr_map  = cfg_we_i && (cfg_sel_i == CFG_MAP);
  assign wr_lim  = cfg_we_i && (cfg_sel_i == CFG_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      base_tag_o <= BASE_RST[ADDR_W-1:WIN_LOG2];
    else if (wr_base) base_tag_o <= cfg_wdata_i[ADDR_W-1:WIN_LOG2];
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic sel_hit;
    assign sel_hit = (cfg_idx_i == SEG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               map_o[g] <= PE_W'(g);
      else if (wr_map && sel_hit) map_o[g] <= cfg_wdata_i[PE_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               limit_o[g] <= LIM_FULL;
      else if (wr_lim && sel_hit) limit_o[g] <= cfg_wdata_i[LIM_W-1:0];
    end
  end
endmodule

// File: rtl/mmio_seg_lookup.sv
module mmio_seg_lookup #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_LOG2  = 30,
  parameter int unsigned NUM_SEG   = 128,
  parameter int unsigned SEG_W     = 7,
  parameter int unsigned PE_W      = 7,
  parameter int unsigned LIM_W     = 24,
  parameter int unsigned SEG_SHIFT = 23,
  localparam int unsigned TAG_W = ADDR_W - WIN_LOG2
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [TAG_W-1:0]              base_tag_i,
  input  logic [NUM_SEG-1:0][PE_W-1:0]  map_i,
  input  logic [NUM_SEG-1:0][LIM_W-1:0] limit_i,
  output logic                          hit_o,
  output logic [PE_W-1:0]               pe_o,
  output logic                          over_o
);
  logic [SEG_W-1:0]     seg;
  logic [SEG_SHIFT-1:0] off;

  assign hit_o  = (addr_i[ADDR_W-1:WIN_LOG2] == base_tag_i);
  assign seg    = addr_i[WIN_LOG2-1:SEG_SHIFT];
  assign off    = addr_i[SEG_SHIFT-1:0];
  assign pe_o   = map_i[seg];
  // offset at or past the claimed bytes lands on no device
  assign over_o = (LIM_W'(off) >= limit_i[seg]);
endmodule

// File: rtl/mmio_freeze_tbl.sv
module mmio_freeze_tbl #(
  parameter int unsigned NUM_PE = 128,
  parameter int unsigned PE_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [PE_W-1:0]   set_pe_i,
  input  logic              clr_i,
  input  logic [PE_W-1:0]   clr_pe_i,
  output logic [NUM_PE-1:0] frozen_o
);
  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    logic set_hit, clr_hit;
    assign set_hit = set_i && (set_pe_i == PE_W'(g));
    assign clr_hit = clr_i && (clr_pe_i == PE_W'(g));

    // a fresh violation outranks a concurrent clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      frozen_o[g] <= 1'b0;
      else if (set_hit) frozen_o[g] <= 1'b1;
      else if (clr_hit) frozen_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/mmio_seg_decoder.sv
module mmio_seg_decoder
  import mmio_seg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_LOG2 = 30,
  parameter int unsigned NUM_PE   = 128,
  parameter logic [ADDR_W-1:0] BASE_RST = 32'hC000_0000,
  localparam int unsigned NUM_SEG   = NUM_PE,
  localparam int unsigned SEG_W     = $clog2(NUM_SEG),
  localparam int unsigned PE_W      = $clog2(NUM_PE),
  localparam int unsigned SEG_SHIFT = WIN_LOG2 - SEG_W,
  localparam int unsigned LIM_W     = SEG_SHIFT + 1,
  localparam int unsigned TAG_W     = ADDR_W - WIN_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [SEG_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_fwd_o,
  output logic              rsp_err_o,
  output logic [PE_W-1:0]   rsp_pe_o
);
  logic [TAG_W-1:0]              base_tag;
  logic [NUM_SEG-1:0][PE_W-1:0]  map;
  logic [NUM_SEG-1:0][LIM_W-1:0] limit;
  logic [NUM_PE-1:0]             frozen;
  logic                          lk_hit, lk_over;
  logic [PE_W-1:0]               lk_pe;
  logic                          pe_frz, viol, clr;
  verdict_t                      vd_d, vd_q;
  logic                          vld_q;
  logic [PE_W-1:0]               pe_q;

  mmio_win_regs #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .NUM_SEG(NUM_SEG), .SEG_W(SEG_W),
    .PE_W(PE_W), .LIM_W(LIM_W), .SEG_SHIFT(SEG_SHIFT), .BASE_RST(BASE_RST)
  ) i_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_idx_i, .cfg_wdata_i,
    .base_tag_o(base_tag), .map_o(map), .limit_o(limit)
  );

  mmio_seg_lookup #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .NUM_SEG(NUM_SEG), .SEG_W(SEG_W),
    .PE_W(PE_W), .LIM_W(LIM_W), .SEG_SHIFT(SEG_SHIFT)
  ) i_lookup (
    .addr_i(req_addr_i), .base_tag_i(base_tag), .map_i(map), .limit_i(limit),
    .hit_o(lk_hit), .pe_o(lk_pe), .over_o(lk_over)
  );

  assign pe_frz = frozen[lk_pe];
  assign viol   = req_valid_i && lk_hit && !pe_frz && lk_over;
  assign clr    = cfg_we_i && (cfg_sel_i == CFG_CLEAR);

  mmio_freeze_tbl #(.NUM_PE(NUM_PE), .PE_W(PE_W)) i_frz (
    .clk_i, .rst_ni,
    .set_i(viol), .set_pe_i(lk_pe),
    .clr_i(clr),  .clr_pe_i(cfg_wdata_i[PE_W-1:0]),
    .frozen_o(frozen)
  );

  always_comb begin
    vd_d = '0;
    if (req_valid_i && lk_hit) begin
      vd_d.hit = 1'b1;
      vd_d.err = pe_frz || lk_over;
      vd_d.fwd = !vd_d.err;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      vd_q  <= '0;
      pe_q  <= '0;
    end else begin
      vld_q <= req_valid_i;
      vd_q  <= vd_d;
      pe_q  <= vd_d.hit ? lk_pe : '0;
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_hit_o   = vd_q.hit;
  assign rsp_fwd_o   = vd_q.fwd;
  assign rsp_err_o   = vd_q.err;
  assign rsp_pe_o    = pe_q;
endmodule

// File: rtl/mmio_seg_decoder_chk.sv
module mmio_seg_decoder_chk #(
  parameter int unsigned NUM_PE = 128,
  parameter int unsigned PE_W   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_fwd_o,
  input logic              rsp_err_o,
  input logic [PE_W-1:0]   rsp_pe_o,
  input logic [NUM_PE-1:0] frozen
);
  logic [NUM_PE-1:0] frz_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frz_prev <= '0;
    else         frz_prev <= frozen;
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R9
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_fwd_o && !rsp_err_o); // R9
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> !rsp_fwd_o && !rsp_err_o && rsp_pe_o == '0); // R2
  AST_FWD_XOR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> rsp_fwd_o != rsp_err_o); // R6
  AST_FROZEN_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fwd_o |-> !frz_prev[rsp_pe_o]); // R7
  AST_VIOL_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o && !frz_prev[rsp_pe_o] |-> frozen[rsp_pe_o]); // R8
endmodule

bind mmio_seg_decoder mmio_seg_decoder_chk #(.NUM_PE(NUM_PE), .PE_W(PE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_fwd_o(rsp_fwd_o),
  .rsp_err_o(rsp_err_o), .rsp_pe_o(rsp_pe_o), .frozen(frozen)
);

// File: tb/test_mmio_seg_decoder.sv
`timescale 1ns/1ps
module test_mmio_seg_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [6:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_fwd, rsp_err;
  logic [6:0]  rsp_pe;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic       hit;
    logic       fwd;
    logic       err;
    logic [6:0] pe;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  mmio_seg_decoder i_mmio_seg_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_fwd_o(rsp_fwd),
    .rsp_err_o(rsp_err), .rsp_pe_o(rsp_pe)
  );

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected response: actual valid=1 expected valid=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_hit !== e.hit || rsp_fwd !== e.fwd || rsp_err !== e.err || rsp_pe !== e.pe) begin
          bad++;
          $display("FAIL %s actual hit=%0b fwd=%0b err=%0b pe=%0d expected hit=%0b fwd=%0b err=%0b pe=%0d",
                   e.tag, rsp_hit, rsp_fwd, rsp_err, rsp_pe, e.hit, e.fwd, e.err, e.pe);
        end
      end
    end
  end

  task automatic step(input logic do_req, input logic [31:0] addr,
                      input logic do_cfg, input logic [1:0] sel, input logic [6:0] idx,
                      input logic [31:0] data,
                      input logic eh, input logic ef, input logic ee, input logic [6:0] ep,
                      input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = do_req; req_addr = addr;
    cfg_we = do_cfg; cfg_sel = sel; cfg_idx = idx; cfg_wdata = data;
    if (do_req) begin
      e.hit = eh; e.fwd = ef; e.err = ee; e.pe = ep; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic acc(input logic [31:0] addr, input logic eh, input logic ef,
                     input logic ee, input logic [6:0] ep, input string tag);
    step(1'b1, addr, 1'b0, 2'd0, 7'd0, 32'd0, eh, ef, ee, ep, tag);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [6:0] idx, input logic [31:0] data);
    step(1'b0, 32'd0, 1'b1, sel, idx, data, 1'b0, 1'b0, 1'b0, 7'd0, "");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, 32'd0, 1'b0, 2'd0, 7'd0, 32'd0, 1'b0, 1'b0, 1'b0, 7'd0, "");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_fwd !== 1'b0 || rsp_err !== 1'b0 || rsp_hit !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs: actual v=%0b h=%0b f=%0b e=%0b expected all 0",
               rsp_valid, rsp_hit, rsp_fwd, rsp_err);
    end

    // R2 outside window
    acc(32'h1000_0000, 0, 0, 0, 7'd0, "R2 low miss");
    acc(32'hBFFF_FFFC, 0, 0, 0, 7'd0, "R2 just below base");
    // R1 R3 identity map, full claim
    acc(32'hC000_0000, 1, 1, 0, 7'd0,   "R3 seg0");
    acc(32'hC080_0004, 1, 1, 0, 7'd1,   "R3 seg1");
    acc(32'hFFFF_FFF0, 1, 1, 0, 7'd127, "R1 seg127 full claim");
    idle(2);

    // R4 two segments on one PE
    cfg(2'd1, 7'd5, 32'd9);
    cfg(2'd1, 7'd6, 32'd9);
    acc(32'hC280_0010, 1, 1, 0, 7'd9, "R4 seg5 to pe9");
    acc(32'hC300_0000, 1, 1, 0, 7'd9, "R4 seg6 to pe9");

    // R5 R6 limit boundary
    cfg(2'd2, 7'd6, 32'h0000_1000);
    acc(32'hC300_0FFF, 1, 1, 0, 7'd9, "R5 last claimed byte");
    acc(32'hC300_1000, 1, 0, 1, 7'd9, "R6 first unclaimed byte");
    acc(32'hC280_0000, 1, 0, 1, 7'd9, "R7 frozen via other segment");
    acc(32'hC080_0000, 1, 1, 0, 7'd1, "R6 other PE unaffected");

    // R8 clear
    cfg(2'd3, 7'd0, 32'd3);
    acc(32'hC280_0000, 1, 0, 1, 7'd9, "R8 clear of other PE no effect");
    cfg(2'd3, 7'd0, 32'd9);
    acc(32'hC280_0000, 1, 1, 0, 7'd9, "R8 clear releases PE");

    // R11 write same cycle as request
    step(1'b1, 32'hC300_0010, 1'b1, 2'd2, 7'd6, 32'd0, 1, 1, 0, 7'd9, "R11 old limit used");
    acc(32'hC300_0000, 1, 0, 1, 7'd9, "R11 new limit zero");
    cfg(2'd3, 7'd0, 32'd9);
    // R8 set beats clear
    step(1'b1, 32'hC300_0000, 1'b1, 2'd3, 7'd0, 32'd9, 1, 0, 1, 7'd9, "R8 violation with clear");
    acc(32'hC280_0000, 1, 0, 1, 7'd9, "R8 freeze wins over clear");
    cfg(2'd3, 7'd0, 32'd9);
    acc(32'hC280_0000, 1, 1, 0, 7'd9, "R8 released again");

    // R10 relocate window
    cfg(2'd0, 7'd0, 32'h4123_4567);
    acc(32'hC000_0000, 0, 0, 0, 7'd0,   "R10 old window missed");
    acc(32'h4080_0000, 1, 1, 0, 7'd1,   "R10 new window seg1");
    acc(32'h4280_0000, 1, 1, 0, 7'd9,   "R10 new window seg5");
    acc(32'h7FFF_FFFF, 1, 1, 0, 7'd127, "R10 top of new window");
    idle(3);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R9 missing responses: actual pending=%0d expected 0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule